// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Per-Pin Masked Writes

The block is one eight-pin general-purpose I/O port on a small 32-bit register bus. For every pin it keeps three control bits: a GPIO-ownership bit, an output-enable bit and an output-level bit. It drives the output enables and output levels straight to the pad logic. Pin inputs pass through a two-stage synchronizer into a read-only input register.

Each control register can be reached at two addresses. The plain address loads all eight bits from the low byte of the write data. The masked alias updates only the pins whose select bit is set in the second byte. This lets software on several threads flip single pins without a read-modify-write sequence and without locking.

The block also presents each pin's effective level: the driven level for pins whose output is enabled, and the synchronized input for all other pins.

Top module: `gpio_port`

## Requirements
- R1: While rst_ni is low, and after it rises until the first write, every control register is 0. That is, pin_gpio_o, pin_oe_o and pin_o are all 0, and every register read returns 0.
- R2: A write to a plain control address loads bits 7:0 of the write data into that register, and bits 31:8 are ignored. The plain addresses, relative to the port base, are 0x00 for ownership, 0x10 for output enable and 0x20 for output level.
- R3: A write to a masked alias (MASK_BASE + 0x00, 0x10 or 0x20 above the port base) sets pin n to write-data bit n only where bit 8+n is 1. Pins whose select bit is 0 keep their value.
- R4: A read of a plain or masked control address returns that register in bits 7:0, and bits 31:8 read as 0.
- R5: The input register at port base + 0x30 returns pin_i as it was two clock edges earlier.
- R6: A write to the input address changes no control register and does not change the input register's contents.
- R7: For each pin n, pin_val_o[n] equals pin_o[n] when pin_oe_o[n] is 1, and the synchronized input bit otherwise.
- R8: pin_gpio_o, pin_oe_o and pin_o present the ownership, output-enable and output-level registers directly, with no extra delay after the write edge.
- R9: The port base is PORT_IDX*4. Writes to any address that matches none of the port's seven addresses change nothing, and reads of such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (12) | Byte address of the access |
| we_i | input | 1 | Write strobe, taken on the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pin_i | input | NPIN (8) | Raw pad inputs |
| pin_o | output | NPIN (8) | Output level register |
| pin_oe_o | output | NPIN (8) | Output enable register |
| pin_gpio_o | output | NPIN (8) | Ownership register; 1 means the pin is under GPIO control |
| pin_val_o | output | NPIN (8) | Effective pin level |

## Verification
The assertions check several properties on every cycle:
- a masked write leaves each unselected pin unchanged;
- a plain write loads exactly the low byte;
- a register holds its value when it is not addressed;
- the read data never carries bits above the pin field;
- a write to the input address leaves all control state untouched.

The bench's scenarios are needed for the rest:
- the exact address map and the per-port base;
- the merge arithmetic for particular mask and value pairs;
- the two-edge latency of the synchronizer;
- the effective-level mux under mixed directions.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned OFS_CFG = 'h00;
  localparam int unsigned OFS_OE  = 'h10;
  localparam int unsigned OFS_OUT = 'h20;
  localparam int unsigned OFS_IN  = 'h30;
  localparam int unsigned NCTL    = 3;

  typedef enum logic [1:0] {
    CTL_CFG = 2'd0,
    CTL_OE  = 2'd1,
    CTL_OUT = 2'd2
  } ctl_e;

  function automatic int unsigned ctl_ofs(input int unsigned idx);
    case (idx)
      0:       return OFS_CFG;
      1:       return OFS_OE;
      default: return OFS_OUT;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_ctl_reg.sv
module gpio_ctl_reg #(
  parameter int unsigned NPIN = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            dir_we_i,
  input  logic            msk_we_i,
  input  logic [NPIN-1:0] val_i,
  input  logic [NPIN-1:0] sel_i,
  output logic [NPIN-1:0] q_o
);
  logic [NPIN-1:0] q_d, q_q;

  always_comb begin
    q_d = q_q;
    if (dir_we_i)      q_d = val_i;
    else if (msk_we_i) q_d = (q_q & ~sel_i) | (val_i & sel_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  assert_masked_keep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msk_we_i |=> ((q_q ^ $past(q_q)) & ~$past(sel_i)) == '0);

  assert_masked_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msk_we_i |=> ((q_q ^ $past(val_i)) & $past(sel_i)) == '0);

  assert_direct_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_we_i |=> q_q == $past(val_i));

  assert_hold_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dir_we_i || msk_we_i) |=> $stable(q_q));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned NPIN        = 8,
  parameter int unsigned PORT_IDX    = 0,
  parameter int unsigned PORT_STRIDE = 4,
  parameter int unsigned MASK_BASE   = 'h80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [NPIN-1:0]   pin_i,
  output logic [NPIN-1:0]   pin_o,
  output logic [NPIN-1:0]   pin_oe_o,
  output logic [NPIN-1:0]   pin_gpio_o,
  output logic [NPIN-1:0]   pin_val_o
);
  localparam int unsigned DW   = 32;
  localparam int unsigned BASE = PORT_IDX * PORT_STRIDE;

  logic [NPIN-1:0] ctl_q [NCTL];
  logic [NCTL-1:0] dir_hit, msk_hit;
  logic            in_hit;
  logic [NPIN-1:0] in_sync;
  logic [NPIN-1:0] wr_val, wr_sel;
  logic [NPIN-1:0] rd_val;
  logic            unused_wdata;

  assign wr_val       = wdata_i[NPIN-1:0];
  assign wr_sel       = wdata_i[2*NPIN-1:NPIN];
  assign unused_wdata = ^wdata_i[DW-1:2*NPIN];
  assign in_hit       = addr_i == ADDR_W'(BASE + OFS_IN);

  for (genvar g = 0; g < NCTL; g++) begin : g_ctl
    assign dir_hit[g] = addr_i == ADDR_W'(BASE + ctl_ofs(g));
    assign msk_hit[g] = addr_i == ADDR_W'(MASK_BASE + BASE + ctl_ofs(g));

    gpio_ctl_reg #(.NPIN(NPIN)) u_reg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .dir_we_i (we_i && dir_hit[g]),
      .msk_we_i (we_i && msk_hit[g]),
      .val_i    (wr_val),
      .sel_i    (wr_sel),
      .q_o      (ctl_q[g])
    );
  end

  gpio_sync2 #(.W(NPIN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (in_sync)
  );

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NCTL; i++)
      if (dir_hit[i] || msk_hit[i]) rd_val = ctl_q[i];
    if (in_hit) rd_val = in_sync;
  end

  assign rdata_o    = DW'(rd_val);
  assign pin_gpio_o = ctl_q[CTL_CFG];
  assign pin_oe_o   = ctl_q[CTL_OE];
  assign pin_o      = ctl_q[CTL_OUT];
  // output-enabled pins report the driven level, the rest the pad
  assign pin_val_o  = (pin_o & pin_oe_o) | (in_sync & ~pin_oe_o);

  assert_rd_upper_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DW-1:NPIN] == '0);

  assert_in_write_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && in_hit) |=> $stable(pin_gpio_o) && $stable(pin_oe_o) && $stable(pin_o));

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (pin_gpio_o == '0) && (pin_oe_o == '0) && (pin_o == '0));
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out, pin_oe, pin_gpio, pin_val;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  gpio_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe),
    .pin_gpio_o(pin_gpio), .pin_val_o(pin_val)
  );

  typedef struct packed {
    logic [11:0] wa;
    logic [31:0] wd;
    logic [11:0] ra;
    logic [31:0] ex;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{12'h000, 32'hFFFF_FFA5, 12'h000, 32'h0000_00A5, 4'd2}, // R2 upper ignored
    '{12'h080, 32'h0000_0F0A, 12'h080, 32'h0000_00AA, 4'd3}, // R3 low nibble only
    '{12'h080, 32'h0000_0000, 12'h000, 32'h0000_00AA, 4'd3}, // R3 empty mask
    '{12'h010, 32'h0000_003C, 12'h010, 32'h0000_003C, 4'd2}, // R2
    '{12'h090, 32'h0000_C3FF, 12'h010, 32'h0000_00FF, 4'd3}, // R3 set edges
    '{12'h090, 32'h0000_8100, 12'h090, 32'h0000_007E, 4'd4}, // R4 clear edges, alias read
    '{12'h020, 32'h0000_0055, 12'h020, 32'h0000_0055, 4'd2}, // R2
    '{12'h0A0, 32'h1234_FFAA, 12'h0A0, 32'h0000_00AA, 4'd4}, // R4 full mask
    '{12'h0A0, 32'h0000_0201, 12'h020, 32'h0000_00A8, 4'd3}, // R3 unselected bit0 kept
    '{12'h004, 32'h0000_00FF, 12'h000, 32'h0000_00AA, 4'd9}, // R9 other port
    '{12'h004, 32'h0000_00FF, 12'h004, 32'h0000_0000, 4'd9}, // R9 unmapped read
    '{12'h030, 32'h0000_00FF, 12'h030, 32'h0000_0000, 4'd6}  // R6 input not writable
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    // R1: state held at zero during reset
    check("R1", {8'h0, pin_gpio, pin_oe, pin_out}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 'h40; a += 'h10) begin
      bus_rd(12'(a), rv);
      check("R1", rv, 32'h0);
    end

    for (int i = 0; i < NV; i++) begin
      bus_wr(VEC[i].wa, VEC[i].wd);
      bus_rd(VEC[i].ra, rv);
      check($sformatf("R%0d vec%0d", VEC[i].req, i), rv, VEC[i].ex);
    end

    // R8: pads follow the registers directly
    check("R8 gpio", {24'h0, pin_gpio}, 32'hAA);
    check("R8 oe",   {24'h0, pin_oe},   32'h7E);
    check("R8 out",  {24'h0, pin_out},  32'hA8);

    // R5: two-edge synchronizer latency
    @(negedge clk);
    pin_in = 8'h0F;
    addr = 12'h030;
    @(negedge clk);
    check("R5 one edge", rdata, 32'h0);
    @(negedge clk);
    check("R5 two edges", rdata, 32'h0F);

    // R7: oe=7E out=A8 in=0F -> 28 | 01
    check("R7 mixed", {24'h0, pin_val}, 32'h29);
    bus_wr(12'h010, 32'h0);
    check("R7 all input", {24'h0, pin_val}, 32'h0F);
    bus_wr(12'h010, 32'hFF);
    check("R7 all output", {24'h0, pin_val}, 32'hA8);

    // R6: input write leaves the input value intact
    bus_wr(12'h030, 32'h0000_FFF0);
    bus_rd(12'h030, rv);
    check("R6 input kept", rv, 32'h0F);

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async", {8'h0, pin_gpio, pin_oe, pin_out}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    bus_rd(12'h020, rv);
    check("R1 after", rv, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule